// File: doc/BRIEF.md
# Floating-Point Significand Rounder

This combinational stage takes the unrounded significand from a floating-point datapath and brings it to its target width. The input significand carries `EXTRA_W` low-order bits below the least significant kept bit. The top one of these is the guard bit. The remaining ones are a sticky field: each of them is the OR of everything that was shifted out below its position. Together with the sign and a two-bit mode select, these bits decide whether the kept part is incremented by one unit in the last place.

Four modes are supported. Mode 00 is round-to-nearest with ties going to the even candidate, and it is the default a datapath uses. Mode 01 truncates toward zero. Mode 10 rounds toward positive infinity and mode 11 rounds toward negative infinity. When an increment overflows the kept field, the stage raises a carry flag, and the downstream normalizer uses it to shift right and bump the exponent. An inexact flag reports that any discarded bit was nonzero.

The increment can be built either as a plain adder or as a trailing-ones toggle network. A parameter selects which one.

Top module: `fp_round_unit`

## Requirements
- R1: With mode 01 (toward zero), `sig_o` equals the kept bits `sig_i[IN_W-1:EXTRA_W]` and `carry_o` is 0, whatever the sign and the extra bits are.
- R2: With mode 00 (nearest-even), when the guard bit (`sig_i[EXTRA_W-1]`) is 1 and any sticky bit is 1, the kept value is incremented.
- R3: With mode 00, when the guard bit is 0, the kept value passes through unchanged.
- R4: With mode 00, when the guard bit is 1 and all sticky bits are 0 (an exact half), the result is the even candidate. A kept value with LSB 0 is unchanged, and one with LSB 1 is incremented.
- R5: With mode 10 (toward +infinity), a positive value (`sign_i`=0) with any nonzero extra bit is incremented. A negative value is truncated.
- R6: With mode 11 (toward -infinity), a negative value (`sign_i`=1) with any nonzero extra bit is incremented. A positive value is truncated.
- R7: When all extra bits are 0, the output equals the kept bits in every mode, `carry_o` is 0 and `inexact_o` is 0.
- R8: `inexact_o` is 1 exactly when any extra bit is nonzero, in every mode.
- R9: When an all-ones kept value is incremented, `carry_o` is 1 and `sig_o` is all zeros. In every other case `carry_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sign_i | input | 1 | Sign of the value being rounded (1 = negative) |
| sig_i | input | MAN_W+EXTRA_W | Unrounded magnitude: kept bits on top, guard and sticky bits below |
| mode_i | input | 2 | Rounding mode: 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| sig_o | output | MAN_W | Rounded significand |
| carry_o | output | 1 | Increment overflowed the kept field; renormalization needed |
| inexact_o | output | 1 | Some discarded bit was nonzero |

## Verification
Immediate assertions inside the RTL check these properties on every input change:
- truncation never increments;
- directed modes never increment a value whose sign points away from their direction;
- an exact input passes through untouched;
- an exact half with an even LSB stays put in nearest mode;
- an incrementer carry always leaves a zero field.

The assertions cannot show that the positive decisions are right. That means the increments above half, on odd ties and on the directed side, and also the agreement between the two incrementer variants. The bench's scoreboard shows these by comparing both builds against an arithmetic model. It runs directed corner values and a sweep across all modes and signs.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

   typedef enum logic [1:0] {
      RM_NEAR_EVEN = 2'b00,
      RM_TO_ZERO   = 2'b01,
      RM_TO_POS    = 2'b10,
      RM_TO_NEG    = 2'b11
   } rnd_mode_e;

   typedef struct packed {
      logic guard;
      logic sticky;
      logic inexact;
   } tail_info_t;

endpackage

// File: rtl/fpr_tail_split.sv
module fpr_tail_split
   import fpr_pkg::*;
#(
   parameter int EXTRA_W = 2
) (
   input  logic [EXTRA_W-1:0] tail_i,
   output tail_info_t         info_o
);
   localparam int STICKY_W = EXTRA_W - 1;

   generate
      if (EXTRA_W < 2) begin : g_bad_w
         $error("fpr_tail_split: EXTRA_W must be at least 2");
      end
   endgenerate

   logic sticky_or;

   generate
      if (STICKY_W == 1) begin : g_one_sticky
         assign sticky_or = tail_i[0];
      end else begin : g_wide_sticky
         assign sticky_or = |tail_i[STICKY_W-1:0];
      end
   endgenerate

   always_comb begin
      info_o.guard   = tail_i[EXTRA_W-1];
      info_o.sticky  = sticky_or;
      info_o.inexact = tail_i[EXTRA_W-1] | sticky_or;
   end

   always_comb begin
      if (!$isunknown(tail_i)) begin
         // R8
         tail_zero_chk: assert (info_o.inexact || (!info_o.guard && !info_o.sticky))
            else $error("inexact low while guard/sticky set");
      end
   end

endmodule

// File: rtl/fpr_round_decide.sv
module fpr_round_decide
   import fpr_pkg::*;
(
   input  rnd_mode_e  mode_i,
   input  logic       sign_i,
   input  logic       lsb_i,
   input  tail_info_t tail_i,
   output logic       inc_o
);
   logic lost;

   always_comb begin
      lost = tail_i.guard | tail_i.sticky;
      unique case (mode_i)
         RM_NEAR_EVEN: inc_o = tail_i.guard & (tail_i.sticky | lsb_i);
         RM_TO_ZERO:   inc_o = 1'b0;
         RM_TO_POS:    inc_o = ~sign_i & lost;
         RM_TO_NEG:    inc_o = sign_i & lost;
         default:      inc_o = 1'b0;
      endcase
   end

   always_comb begin
      if (!$isunknown({mode_i, sign_i, lsb_i, tail_i})) begin
         // R1
         trunc_no_inc_chk: assert (!(mode_i == RM_TO_ZERO) || !inc_o)
            else $error("truncate mode incremented");
         // R5 R6
         dir_away_chk: assert (!((mode_i == RM_TO_POS && sign_i) ||
                                 (mode_i == RM_TO_NEG && !sign_i)) || !inc_o)
            else $error("directed mode incremented away from its direction");
         // R3
         near_low_chk: assert (!(mode_i == RM_NEAR_EVEN && !tail_i.guard) || !inc_o)
            else $error("nearest mode incremented below half");
      end
   end

endmodule

// File: rtl/fpr_sig_incr.sv
module fpr_sig_incr #(
   parameter int MAN_W    = 24,
   parameter bit FAST_INC = 1'b1
) (
   input  logic [MAN_W-1:0] a_i,
   input  logic             inc_i,
   output logic [MAN_W-1:0] y_o,
   output logic             co_o
);
   localparam int SUM_W = MAN_W + 1;

   generate
      if (FAST_INC) begin : g_toggle
         logic [MAN_W:0] run;
         assign run[0] = inc_i;
         for (genvar i = 0; i < MAN_W; i++) begin : g_bit
            assign y_o[i]     = a_i[i] ^ run[i];
            assign run[i + 1] = run[i] & a_i[i];
         end
         assign co_o = run[MAN_W];
      end else begin : g_adder
         logic [SUM_W-1:0] sum;
         assign sum  = {1'b0, a_i} + SUM_W'(inc_i);
         assign y_o  = sum[MAN_W-1:0];
         assign co_o = sum[MAN_W];
      end
   endgenerate

   always_comb begin
      if (!$isunknown({a_i, inc_i})) begin
         // R9
         carry_zero_chk: assert (!co_o || (y_o == '0))
            else $error("carry out with nonzero field");
         // R9
         no_inc_pass_chk: assert (inc_i || (!co_o && y_o == a_i))
            else $error("field changed without increment");
      end
   end

endmodule

// File: rtl/fp_round_unit.sv
module fp_round_unit
   import fpr_pkg::*;
#(
   parameter int MAN_W    = 24,
   parameter int EXTRA_W  = 2,
   parameter bit FAST_INC = 1'b1
) (
   input  logic                     sign_i,
   input  logic [MAN_W+EXTRA_W-1:0] sig_i,
   input  logic [1:0]               mode_i,
   output logic [MAN_W-1:0]         sig_o,
   output logic                     carry_o,
   output logic                     inexact_o
);
   localparam int IN_W = MAN_W + EXTRA_W;

   generate
      if (MAN_W < 2) begin : g_bad_man
         $error("fp_round_unit: MAN_W must be at least 2");
      end
      if (EXTRA_W < 2) begin : g_bad_extra
         $error("fp_round_unit: EXTRA_W must be at least 2");
      end
   endgenerate

   logic [MAN_W-1:0]   kept;
   logic [EXTRA_W-1:0] tail;
   tail_info_t         tinfo;
   rnd_mode_e          mode;
   logic               bump;

   assign kept = sig_i[IN_W-1:EXTRA_W];
   assign tail = sig_i[EXTRA_W-1:0];
   assign mode = rnd_mode_e'(mode_i);

   fpr_tail_split #(.EXTRA_W(EXTRA_W)) u_tail (
      .tail_i (tail),
      .info_o (tinfo)
   );

   fpr_round_decide u_decide (
      .mode_i (mode),
      .sign_i (sign_i),
      .lsb_i  (kept[0]),
      .tail_i (tinfo),
      .inc_o  (bump)
   );

   fpr_sig_incr #(.MAN_W(MAN_W), .FAST_INC(FAST_INC)) u_incr (
      .a_i   (kept),
      .inc_i (bump),
      .y_o   (sig_o),
      .co_o  (carry_o)
   );

   assign inexact_o = tinfo.inexact;

   always_comb begin
      if (!$isunknown({sign_i, sig_i, mode_i})) begin
         // R7
         exact_pass_chk: assert (inexact_o || (sig_o == kept && !carry_o))
            else $error("exact input altered");
         // R4
         tie_even_chk: assert (!(mode_i == 2'b00 && tail == {1'b1, {(EXTRA_W-1){1'b0}}}
                                 && !kept[0]) || (sig_o == kept))
            else $error("even tie moved");
      end
   end

endmodule

// File: tb/fp_round_unit_test.sv
module fp_round_unit_test;
   localparam int MW = 8;
   localparam int XW = 2;
   localparam int IW = MW + XW;

   typedef struct {
      logic [MW-1:0] e_sig;
      logic          e_co;
      logic          e_inx;
      string         req;
   } exp_t;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #5 clk = ~clk;

   logic          sign_i;
   logic [IW-1:0] sig_i;
   logic [1:0]    mode_i;
   logic [MW-1:0] sig_f, sig_r;
   logic          co_f, co_r, inx_f, inx_r;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   exp_t q[$];

   fp_round_unit #(.MAN_W(MW), .EXTRA_W(XW), .FAST_INC(1'b1)) uut (
      .sign_i(sign_i), .sig_i(sig_i), .mode_i(mode_i),
      .sig_o(sig_f), .carry_o(co_f), .inexact_o(inx_f));

   fp_round_unit #(.MAN_W(MW), .EXTRA_W(XW), .FAST_INC(1'b0)) uut_rip (
      .sign_i(sign_i), .sig_i(sig_i), .mode_i(mode_i),
      .sig_o(sig_r), .carry_o(co_r), .inexact_o(inx_r));

   // Arithmetic model: the quarter-ULP fraction decides the increment.
   task automatic drive(input logic s, input logic [IW-1:0] v, input logic [1:0] m,
                        input string req);
      exp_t e;
      int kept, frac, up, sum;
      kept = int'(v >> XW);
      frac = int'(v[XW-1:0]);
      up = 0;
      case (m)
         2'b00: up = (frac > 2 || (frac == 2 && (kept % 2) == 1)) ? 1 : 0;
         2'b01: up = 0;
         2'b10: up = (!s && frac != 0) ? 1 : 0;
         default: up = (s && frac != 0) ? 1 : 0;
      endcase
      sum = kept + up;
      e.e_sig = MW'(sum % (1 << MW));
      e.e_co  = (sum >= (1 << MW));
      e.e_inx = (frac != 0);
      e.req   = req;
      @(negedge clk);
      sign_i = s; sig_i = v; mode_i = m;
      q.push_back(e);
   endtask

   initial begin : monitor
      forever begin
         @(posedge clk); #1;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (sig_f !== e.e_sig || co_f !== e.e_co || inx_f !== e.e_inx ||
                sig_r !== e.e_sig || co_r !== e.e_co || inx_r !== e.e_inx) begin
               failures++;
               $display("FAIL %s: got sig=%h/%h co=%b/%b inx=%b/%b exp sig=%h co=%b inx=%b",
                        e.req, sig_f, sig_r, co_f, co_r, inx_f, inx_r,
                        e.e_sig, e.e_co, e.e_inx);
            end
         end
      end
   end

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog: got hung expected done");
         finish_run();
      end
   end

   initial begin : driver
      sign_i = 1'b0; sig_i = '0; mode_i = 2'b00;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // reset state: zero input, exact (R7)
      drive(1'b0, 10'h000, 2'b00, "R7 reset zero");
      // R1 truncate ignores sign and extra bits
      drive(1'b0, {8'h5A, 2'b11}, 2'b01, "R1 trunc pos");
      drive(1'b1, {8'hFF, 2'b11}, 2'b01, "R1 trunc all ones no carry");
      // R2 above half
      drive(1'b0, {8'h40, 2'b11}, 2'b00, "R2 above half");
      drive(1'b1, {8'h41, 2'b11}, 2'b00, "R2 above half neg");
      // R3 below half
      drive(1'b0, {8'h41, 2'b01}, 2'b00, "R3 below half");
      // R4 ties
      drive(1'b0, {8'h42, 2'b10}, 2'b00, "R4 tie even stays");
      drive(1'b0, {8'h43, 2'b10}, 2'b00, "R4 tie odd up");
      // R5 toward +inf
      drive(1'b0, {8'h10, 2'b01}, 2'b10, "R5 pos up");
      drive(1'b1, {8'h10, 2'b11}, 2'b10, "R5 neg trunc");
      // R6 toward -inf
      drive(1'b1, {8'h10, 2'b01}, 2'b11, "R6 neg up");
      drive(1'b0, {8'h10, 2'b11}, 2'b11, "R6 pos trunc");
      // R7 exact in each mode
      for (int m = 0; m < 4; m++)
         drive(m[0], {8'h37, 2'b00}, 2'(m), "R7 exact");
      // R8 inexact in truncate mode too
      drive(1'b0, {8'h20, 2'b01}, 2'b01, "R8 inexact trunc");
      // R9 overflow cases
      drive(1'b0, {8'hFF, 2'b11}, 2'b00, "R9 near overflow");
      drive(1'b0, {8'hFF, 2'b10}, 2'b00, "R9 tie overflow");
      drive(1'b0, {8'hFF, 2'b01}, 2'b10, "R9 pos overflow");
      drive(1'b1, {8'hFF, 2'b01}, 2'b11, "R9 neg overflow");
      // sweep across modes and signs (R2 R3 R4 R5 R6 R8)
      for (int m = 0; m < 4; m++)
         for (int s = 0; s < 2; s++)
            for (int v = 0; v < (1 << IW); v += 29)
               drive(s[0], IW'(v), 2'(m), "R8 sweep");
      wait (q.size() == 0);
      @(posedge clk); #2;
      done = 1'b1;
      finish_run();
   end

endmodule